// File: doc/BRIEF.md
# Gap-2 Write Gate Sequencer

This block decides the byte at which a disk controller turns on its write gate while it writes a sector's data. Once the identification field of the target sector has gone past the head, the controller pulses a start input. The block then counts byte-clock strobes through gap 2. It raises the write gate early enough that the write overwrites the required tail of the gap before the data field begins. Serial encoding, CRC and the data field are handled elsewhere.

A two-bit format select picks the recording scheme. The conventional scheme has a 22-byte gap and none of it is rewritten. Perpendicular recording at the lower rate rewrites the last 19 of 22 bytes. Perpendicular recording at the higher rate rewrites the last 38 of 41 bytes. One code is reserved and behaves exactly like the conventional scheme. The format is captured when the start pulse is accepted and stays fixed for the sector. The gate stays on until an external end-of-write pulse arrives. The block also flags the byte that closes gap 2 and shows the scheme in use.

Top module: `gap2_wgate_seq`

## Requirements
- R1: With `fmt_sel` = 2'b00 (conventional), `wr_gate` rises after the 22nd counted byte strobe following the start, and `gap_end` pulses with that same strobe.
- R2: With `fmt_sel` = 2'b01 (perpendicular, lower rate), `wr_gate` rises after the 3rd counted strobe and `gap_end` pulses after the 22nd.
- R3: `fmt_sel` = 2'b10 is reserved and behaves exactly like 2'b00: gate and gap end after the 22nd strobe, and `active_mode` reads 2'b00.
- R4: With `fmt_sel` = 2'b11 (perpendicular, higher rate), `wr_gate` rises after the 3rd counted strobe and `gap_end` pulses after the 41st.
- R5: Both outputs are registered and appear in the cycle after the clock edge that samples the qualifying strobe. `gap_end` lasts exactly one cycle, and strobes after the gap has closed do not raise it again.
- R6: The format is sampled only when a start is accepted. A later change of `fmt_sel` has no effect until the next sector. `active_mode` shows the captured scheme: 2'b00 conventional, 2'b01 perpendicular lower rate, 2'b10 perpendicular higher rate.
- R7: Once raised, `wr_gate` stays high until `wr_end` is sampled, and it is low in the following cycle. A `wr_end` before the gate rises aborts the sector, and no gate follows. A `wr_end` while idle has no effect.
- R8: A start pulse while a sector is in progress is ignored: the count is not restarted and the captured format is kept.
- R9: Byte strobes while idle are not counted. A strobe in the same cycle as an accepted start is not counted.
- R10: A synchronous active-low reset drops `wr_gate` and `gap_end`, sets `active_mode` to 2'b00 and returns to idle, so the next sector counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Format select; bit 1 picks higher rate/reserved, bit 0 picks perpendicular |
| byte_tick | input | 1 | One-cycle strobe per byte time |
| id_done | input | 1 | Start pulse at the end of the identification field |
| wr_end | input | 1 | End-of-write pulse |
| wr_gate | output | 1 | Write gate |
| gap_end | output | 1 | One-cycle pulse on the byte that closes gap 2 |
| active_mode | output | 2 | Scheme captured for the current sector |

## Verification
Every result is due one clock after the edge that samples its cause. The gate and the gap-end pulse follow the edge that takes in the qualifying strobe. The mode status follows the edge that accepts the start. The gate drops one edge after `wr_end`. The bench drives each input on a falling edge, holds it across one rising edge, and reads the outputs at the next falling edge. One idle cycle between strobes lets it confirm that `gap_end` has fallen again. Counting strobes one at a time makes an off-by-one error in either threshold visible at the exact strobe where it occurs.

// File: rtl/gap2_pkg.sv
// Shared types and helpers for the gap-2 write gate sequencer.
// Assumes a two-bit format select where bit 0 picks perpendicular recording
// and bit 1 picks the higher rate; code 2'b10 is reserved.
package gap2_pkg;

    typedef enum logic [1:0] {
        MODE_CONV    = 2'b00,
        MODE_PERP_LO = 2'b01,
        MODE_PERP_HI = 2'b10
    } rec_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_PRE   = 2'b01,
        ST_GATED = 2'b10,
        ST_DATA  = 2'b11
    } seq_state_e;

    // Map the raw format select to a recording scheme; reserved falls back.
    function automatic rec_mode_e fmt_to_mode(input logic [1:0] f);
        case (f)
            2'b01:   return MODE_PERP_LO;
            2'b11:   return MODE_PERP_HI;
            default: return MODE_CONV;
        endcase
    endfunction

endpackage

// File: rtl/gap2_len_decode.sv
// Turns the captured recording scheme into two byte thresholds: the total
// gap-2 length and the count at which the write gate turns on.
// Assumes each written portion is no longer than its gap.
module gap2_len_decode
    import gap2_pkg::*;
#(
    parameter int GAP_CONV    = 22,
    parameter int GAP_PERP_LO = 22,
    parameter int WR_PERP_LO  = 19,
    parameter int GAP_PERP_HI = 41,
    parameter int WR_PERP_HI  = 38,
    parameter int CNT_W       = 6
) (
    input  rec_mode_e          mode,
    output logic [CNT_W-1:0]   gap_len,
    output logic [CNT_W-1:0]   gate_at
);

    localparam int GATE_PERP_LO = GAP_PERP_LO - WR_PERP_LO;
    localparam int GATE_PERP_HI = GAP_PERP_HI - WR_PERP_HI;

    // Select both thresholds for the scheme in use.
    always_comb begin
        case (mode)
            MODE_PERP_LO: begin
                gap_len = CNT_W'(GAP_PERP_LO);
                gate_at = CNT_W'(GATE_PERP_LO);
            end
            MODE_PERP_HI: begin
                gap_len = CNT_W'(GAP_PERP_HI);
                gate_at = CNT_W'(GATE_PERP_HI);
            end
            default: begin
                gap_len = CNT_W'(GAP_CONV);
                gate_at = CNT_W'(GAP_CONV);
            end
        endcase
    end

endmodule

// File: rtl/gap2_byte_counter.sv
// Counts byte strobes from a synchronous clear. Assumes the controller stops
// incrementing before the counter could wrap.
module gap2_byte_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    // Clear on reset or new sector, otherwise step on each counted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> cnt != '1);  // R5

endmodule

// File: rtl/gap2_wgate_seq.sv
// Gap-2 write gate sequencer. Accepts a start pulse when idle, captures the
// recording scheme, counts byte strobes and raises the write gate at the
// scheme's threshold; the gate holds until an end-of-write pulse.
// Assumes byte_tick, id_done and wr_end are single-cycle pulses in clk.
module gap2_wgate_seq
    import gap2_pkg::*;
#(
    parameter int GAP_CONV    = 22,
    parameter int GAP_PERP_LO = 22,
    parameter int WR_PERP_LO  = 19,
    parameter int GAP_PERP_HI = 41,
    parameter int WR_PERP_HI  = 38
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fmt_sel,
    input  logic       byte_tick,
    input  logic       id_done,
    input  logic       wr_end,
    output logic       wr_gate,
    output logic       gap_end,
    output logic [1:0] active_mode
);

    localparam int MAX_GAP = (GAP_PERP_HI > GAP_PERP_LO)
                           ? ((GAP_PERP_HI > GAP_CONV) ? GAP_PERP_HI : GAP_CONV)
                           : ((GAP_PERP_LO > GAP_CONV) ? GAP_PERP_LO : GAP_CONV);
    localparam int CNT_W = $clog2(MAX_GAP + 2);

    seq_state_e       state, state_nxt;
    rec_mode_e        mode_q;
    logic             gap_end_q;
    logic [CNT_W-1:0] cnt, cnt_nxt, gap_len, gate_at;
    logic             busy, counting, start_ok, tick_ok, reach_gate, reach_gap;

    gap2_len_decode #(
        .GAP_CONV(GAP_CONV), .GAP_PERP_LO(GAP_PERP_LO), .WR_PERP_LO(WR_PERP_LO),
        .GAP_PERP_HI(GAP_PERP_HI), .WR_PERP_HI(WR_PERP_HI), .CNT_W(CNT_W)
    ) u_dec (
        .mode(mode_q), .gap_len(gap_len), .gate_at(gate_at)
    );

    gap2_byte_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .inc(tick_ok), .cnt(cnt)
    );

    // Qualify incoming pulses against the current state.
    always_comb begin
        busy       = (state != ST_IDLE);
        counting   = (state == ST_PRE) || (state == ST_GATED);
        start_ok   = id_done && !busy;
        tick_ok    = byte_tick && counting && !wr_end;
        cnt_nxt    = cnt + 1'b1;
        reach_gate = tick_ok && (cnt_nxt == gate_at);
        reach_gap  = tick_ok && (cnt_nxt == gap_len);
    end

    // Next-state selection for the sector sequence.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE:  if (start_ok) state_nxt = ST_PRE;
            ST_PRE: begin
                if (wr_end)          state_nxt = ST_IDLE;
                else if (reach_gate) state_nxt = reach_gap ? ST_DATA : ST_GATED;
            end
            ST_GATED: begin
                if (wr_end)          state_nxt = ST_IDLE;
                else if (reach_gap)  state_nxt = ST_DATA;
            end
            default:  if (wr_end) state_nxt = ST_IDLE;
        endcase
    end

    // State, captured scheme and gap-end pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= MODE_CONV;
            gap_end_q <= 1'b0;
        end else begin
            state     <= state_nxt;
            gap_end_q <= reach_gap;
            if (start_ok) mode_q <= fmt_to_mode(fmt_sel);
        end
    end

    // Drive outputs straight from registers.
    always_comb begin
        wr_gate     = (state == ST_GATED) || (state == ST_DATA);
        gap_end     = gap_end_q;
        active_mode = mode_q;
    end

    AST_GATE_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_gate) |-> cnt == gate_at);  // R2
    AST_GAP_END_AT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        gap_end |-> cnt == gap_len);  // R1
    AST_GAP_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        gap_end |=> !gap_end);  // R5
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_end) |=> $stable(active_mode));  // R6
    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate && !wr_end) |=> wr_gate);  // R7
    AST_GATE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_end) |=> !wr_gate);  // R7
    AST_BUSY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_end) |=> busy);  // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !id_done) |=> !wr_gate);  // R9
    AST_GATE_ON_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate && active_mode == 2'b00) |-> cnt == gap_len);  // R3

endmodule

// File: tb/sim_gap2_wgate_seq.sv
module sim_gap2_wgate_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic       byte_tick = 1'b0;
    logic       id_done = 1'b0;
    logic       wr_end = 1'b0;
    logic       wr_gate, gap_end;
    logic [1:0] active_mode;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;

    always #5 clk = ~clk;

    gap2_wgate_seq u0 (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .byte_tick(byte_tick),
        .id_done(id_done), .wr_end(wr_end), .wr_gate(wr_gate),
        .gap_end(gap_end), .active_mode(active_mode)
    );

    // Vector: {fmt[1:0], gate strobe[5:0], gap strobe[5:0], mode[1:0], tag[3:0]}
    localparam logic [19:0] VEC [4] = '{
        {2'b00, 6'd22, 6'd22, 2'b00, 4'd1},
        {2'b01, 6'd3,  6'd22, 2'b01, 4'd2},
        {2'b10, 6'd22, 6'd22, 2'b00, 4'd3},
        {2'b11, 6'd3,  6'd41, 2'b10, 4'd4}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_sector(input logic [1:0] f);
        @(negedge clk); fmt_sel = f; id_done = 1'b1;
        @(negedge clk); id_done = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk); byte_tick = 1'b1;
        @(negedge clk); byte_tick = 1'b0;
    endtask

    task automatic end_pulse();
        @(negedge clk); wr_end = 1'b1;
        @(negedge clk); wr_end = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(wr_gate == 1'b0, "R10 gate in reset", wr_gate, 0);
        chk(gap_end == 1'b0, "R10 gap_end in reset", gap_end, 0);
        chk(active_mode == 2'b00, "R10 mode in reset", active_mode, 0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < 4; v++) begin
            logic [1:0] f, m;
            int ga, gp, tg;
            f  = VEC[v][19:18];
            ga = int'(VEC[v][17:12]);
            gp = int'(VEC[v][11:6]);
            m  = VEC[v][5:4];
            tg = int'(VEC[v][3:0]);
            start_sector(f);
            chk(active_mode == m, $sformatf("R%0d mode status", tg), active_mode, m);
            chk(wr_gate == 1'b0, $sformatf("R%0d gate after start", tg), wr_gate, 0);
            for (int n = 1; n <= gp + 2; n++) begin
                tick_once();
                chk(wr_gate == (n >= ga), $sformatf("R%0d gate strobe %0d", tg, n),
                    wr_gate, (n >= ga));
                chk(gap_end == (n == gp), $sformatf("R%0d gap_end strobe %0d", tg, n),
                    gap_end, (n == gp));
                @(negedge clk);
                chk(gap_end == 1'b0, "R5 gap_end one cycle", gap_end, 0);
            end
            end_pulse();
            chk(wr_gate == 1'b0, "R7 gate drops after end", wr_gate, 0);
        end

        // R6: format change mid-sector has no effect
        start_sector(2'b01);
        fmt_sel = 2'b00;
        repeat (2) tick_once();
        chk(wr_gate == 1'b0, "R6 no gate at 2", wr_gate, 0);
        tick_once();
        chk(wr_gate == 1'b1, "R6 gate at 3 despite change", wr_gate, 1);
        chk(active_mode == 2'b01, "R6 mode held", active_mode, 1);
        end_pulse();

        // R8: start while busy ignored
        start_sector(2'b11);
        repeat (2) tick_once();
        start_sector(2'b00);
        chk(active_mode == 2'b10, "R8 mode kept", active_mode, 2);
        tick_once();
        chk(wr_gate == 1'b1, "R8 count not restarted", wr_gate, 1);
        end_pulse();

        // R9: idle strobes ignored, strobe with start not counted
        repeat (5) tick_once();
        chk(wr_gate == 1'b0, "R9 idle strobes", wr_gate, 0);
        @(negedge clk); fmt_sel = 2'b01; id_done = 1'b1; byte_tick = 1'b1;
        @(negedge clk); id_done = 1'b0; byte_tick = 1'b0;
        repeat (2) tick_once();
        chk(wr_gate == 1'b0, "R9 start strobe not counted", wr_gate, 0);
        tick_once();
        chk(wr_gate == 1'b1, "R9 gate at third", wr_gate, 1);
        end_pulse();

        // R7: abort before gate, and end while idle
        start_sector(2'b00);
        repeat (5) tick_once();
        end_pulse();
        repeat (20) tick_once();
        chk(wr_gate == 1'b0, "R7 abort no gate", wr_gate, 0);
        chk(gap_end == 1'b0, "R7 abort no gap_end", gap_end, 0);
        end_pulse();
        start_sector(2'b11);
        repeat (3) tick_once();
        chk(wr_gate == 1'b1, "R7 idle end ignored", wr_gate, 1);
        repeat (4) @(negedge clk);
        chk(wr_gate == 1'b1, "R7 gate holds", wr_gate, 1);

        // R10: reset mid-sector
        rst_n = 1'b0;
        @(negedge clk);
        chk(wr_gate == 1'b0, "R10 reset drops gate", wr_gate, 0);
        chk(active_mode == 2'b00, "R10 reset mode", active_mode, 0);
        rst_n = 1'b1;
        start_sector(2'b01);
        repeat (2) tick_once();
        chk(wr_gate == 1'b0, "R10 count from zero", wr_gate, 0);
        tick_once();
        chk(wr_gate == 1'b1, "R10 gate after reset", wr_gate, 1);
        end_pulse();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule